// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the order of low-order column addresses that a double-data-rate memory burst visits. A mode write sets the burst length (four or eight beats) and the burst type (sequential or interleaved). A burst start captures a starting column. From the next cycle the block emits one column address per beat, raises a valid flag for the length of the burst, and marks the final beat.

In sequential mode a burst of eight does not count straight through eight addresses. It wraps the low two bits inside the starting group of four, then moves to the other group of four and wraps again. In interleaved mode every beat address is the start address XOR the beat index. A new start on the final beat chains the next burst with no idle cycle.

Some requests are illegal and are reported on one-cycle error pulses. These are: a mode write with an unsupported length code, a start that would cut into a burst of four or land on an odd beat of a burst of eight, and any burst-stop request. An illegal request never changes the running burst or the stored mode.

Top module: `burst_col_seq`

## Requirements
- R1: Mode field bits [2:0] select the length: 3'b010 gives 4 beats and 3'b011 gives 8 beats. Bit [3] selects the type: 0 is sequential and 1 is interleaved. After reset the mode is 4 beats, sequential.
- R2: A mode write with any other length code raises modeErr on the next cycle and leaves both length and type unchanged.
- R3: For a sequential burst of 4, beat i carries low bits (start + i) mod 4.
- R4: For an interleaved burst of 4, beat i carries low bits start[1:0] XOR i.
- R5: For a sequential burst of 8, beat i carries bits [1:0] equal to (start + i) mod 4 and bit [2] equal to start[2] XOR (i >= 4).
- R6: For an interleaved burst of 8, beat i carries bits [2:0] equal to start[2:0] XOR i.
- R7: Column bits above the burst field (from bit 2 up for length 4, from bit 3 up for length 8) equal the start column on every beat.
- R8: An accepted start shows beat 0 on the next cycle. beatValid stays high for exactly the burst length, beatLast is high only on the final beat, and beatValid is low on the cycle after that beat unless a new burst chains on.
- R9: A start while beatLast is high begins the new burst on the next cycle with beatValid held high and startErr low.
- R10: With a burst of 4 running, a start on any beat other than the last is ignored and raises startErr on the next cycle.
- R11: With a burst of 8 running, a start on beat 1, 3 or 5 is accepted and shows the new burst's beat 0 next cycle. A start on beat 0, 2, 4 or 6 is ignored and raises startErr.
- R12: A burst-stop request always raises stopErr on the next cycle and does not change the beat sequence.
- R13: A running burst keeps the length and type captured at its start, even if the mode is rewritten mid-burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| modeWrEn | input | 1 | Mode register write strobe |
| modeField | input | 4 | Mode write value: [2:0] length code, [3] burst type |
| startEn | input | 1 | Burst start strobe (read or write) |
| startCol | input | COL_W | Starting column address |
| stopReq | input | 1 | Burst-stop request (always rejected) |
| beatAddr | output | COL_W | Column address of the current beat |
| beatValid | output | 1 | A burst beat is being presented |
| beatLast | output | 1 | Current beat is the final one of the burst |
| modeErr | output | 1 | Pulse: unsupported length code written |
| startErr | output | 1 | Pulse: start request rejected |
| stopErr | output | 1 | Pulse: burst-stop request rejected |

## Verification
Every result is one register stage from its cause. Beat 0 of an accepted start appears one cycle after the start is sampled, each later beat follows one cycle after the previous one, and every error pulse comes one cycle after the offending strobe. The bench drives inputs at the falling edge and samples one full cycle later at the next falling edge. It checks each beat, including the cycle where a chained or mid-burst start takes over, in the exact cycle it is due, and it checks that every error pulse is gone one cycle after that.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int BEAT_W = 3;
  localparam int MODE_FIELD_W = 4;
  localparam int TYPE_BIT = 3;
  localparam logic [2:0] LEN_CODE_4 = 3'b010;
  localparam logic [2:0] LEN_CODE_8 = 3'b011;

  typedef struct packed {
    logic loadStart;
    logic len8;
    logic interleave;
    logic [BEAT_W-1:0] beatIdx;
  } ctrlStrobes_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic modeWrEn,
  input  logic [MODE_FIELD_W-1:0] modeField,
  input  logic startEn,
  input  logic stopReq,
  output ctrlStrobes_t strobes,
  output logic beatValid,
  output logic beatLast,
  output logic modeErr,
  output logic startErr,
  output logic stopErr
);
  logic modeLen8, modeInter;
  logic curLen8, curInter;
  logic active;
  logic [BEAT_W-1:0] cnt;
  logic [2:0] lenCode;
  logic legalLen, lastNow, midOk, accept;
  logic [BEAT_W-1:0] lastIdx;

  assign lenCode  = modeField[2:0];
  assign legalLen = (lenCode == LEN_CODE_4) || (lenCode == LEN_CODE_8);
  assign lastIdx  = curLen8 ? BEAT_W'(7) : BEAT_W'(3);
  assign lastNow  = active && (cnt == lastIdx);
  // a burst of eight may be cut only so that the new one lands on an even beat
  assign midOk    = active && curLen8 && cnt[0];
  assign accept   = startEn && (!active || lastNow || midOk);

  // mode register: illegal length codes leave the whole setting untouched
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeLen8  <= 1'b0;
      modeInter <= 1'b0;
    end else if (modeWrEn && legalLen) begin
      modeLen8  <= (lenCode == LEN_CODE_8);
      modeInter <= modeField[TYPE_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeErr  <= 1'b0;
      startErr <= 1'b0;
      stopErr  <= 1'b0;
    end else begin
      modeErr  <= modeWrEn && !legalLen;
      startErr <= startEn && !accept;
      stopErr  <= stopReq;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      cnt      <= '0;
      curLen8  <= 1'b0;
      curInter <= 1'b0;
    end else if (accept) begin
      active   <= 1'b1;
      cnt      <= '0;
      curLen8  <= modeLen8;
      curInter <= modeInter;
    end else if (active) begin
      if (lastNow) active <= 1'b0;
      else         cnt    <= cnt + 1'b1;
    end
  end

  always_comb begin
    strobes.loadStart  = accept;
    strobes.len8       = curLen8;
    strobes.interleave = curInter;
    strobes.beatIdx    = cnt;
  end

  assign beatValid = active;
  assign beatLast  = lastNow;

  AST_BAD_MODE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (modeWrEn && !legalLen) |=> (modeErr && $stable(modeLen8) && $stable(modeInter))); // R2
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (beatLast && !startEn) |=> !beatValid); // R8
  AST_SEAMLESS: assert property (@(posedge clk) disable iff (!rst_n)
    (beatLast && startEn) |=> (beatValid && cnt == '0 && !startErr)); // R9
  AST_LEN4_NO_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (beatValid && !curLen8 && !beatLast && startEn) |=> (startErr && $past(cnt) + 1'b1 == cnt)); // R10
  AST_LEN8_ODD_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (beatValid && curLen8 && cnt[0] && !beatLast && startEn) |=> (beatValid && cnt == '0)); // R11
  AST_LEN8_EVEN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (beatValid && curLen8 && !cnt[0] && startEn) |=> startErr); // R11
  AST_STOP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    stopReq |=> stopErr); // R12
  AST_KEEP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (beatValid && !beatLast && !startEn) |=> (beatValid && $stable(curLen8) && $stable(curInter))); // R13
endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [COL_W-1:0] startCol,
  input  ctrlStrobes_t strobes,
  output logic [COL_W-1:0] beatAddr
);
  localparam int FIELD_W = 3;

  logic [COL_W-1:0] startReg;
  logic [1:0] seqLow, xorLow;
  logic topBit;
  logic [FIELD_W-1:0] low3;

  always_ff @(posedge clk) begin
    if (!rst_n)                 startReg <= '0;
    else if (strobes.loadStart) startReg <= startCol;
  end

  // low two bits wrap inside a group of four in both orders
  assign seqLow = startReg[1:0] + strobes.beatIdx[1:0];
  assign xorLow = startReg[1:0] ^ strobes.beatIdx[1:0];
  // bit 2 flips after four beats of a burst of eight, for either order
  assign topBit = strobes.len8 ? (startReg[2] ^ strobes.beatIdx[2]) : startReg[2];
  assign low3   = {topBit, (strobes.interleave ? xorLow : seqLow)};

  generate
    if (COL_W > FIELD_W) begin : g_upper
      assign beatAddr = {startReg[COL_W-1:FIELD_W], low3};
    end else begin : g_narrow
      assign beatAddr = low3[COL_W-1:0];
    end
  endgenerate

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.len8 |-> !strobes.beatIdx[2]); // R3
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic modeWrEn,
  input  logic [MODE_FIELD_W-1:0] modeField,
  input  logic startEn,
  input  logic [COL_W-1:0] startCol,
  input  logic stopReq,
  output logic [COL_W-1:0] beatAddr,
  output logic beatValid,
  output logic beatLast,
  output logic modeErr,
  output logic startErr,
  output logic stopErr
);
  ctrlStrobes_t strobes;

  burst_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .modeWrEn(modeWrEn), .modeField(modeField),
    .startEn(startEn), .stopReq(stopReq), .strobes(strobes),
    .beatValid(beatValid), .beatLast(beatLast),
    .modeErr(modeErr), .startErr(startErr), .stopErr(stopErr)
  );

  burst_seq_dp #(.COL_W(COL_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .startCol(startCol),
    .strobes(strobes), .beatAddr(beatAddr)
  );

  generate
    if (COL_W > 3) begin : g_hold_chk
      AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (beatValid && !beatLast && !startEn) |=>
          (beatAddr[COL_W-1:3] == $past(beatAddr[COL_W-1:3]))); // R7
    end
  endgenerate
endmodule

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;
  localparam int COL_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic modeWrEn = 1'b0;
  logic [3:0] modeField = '0;
  logic startEn = 1'b0;
  logic [COL_W-1:0] startCol = '0;
  logic stopReq = 1'b0;
  logic [COL_W-1:0] beatAddr;
  logic beatValid, beatLast, modeErr, startErr, stopErr;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) u_burst_col_seq (
    .clk(clk), .rst_n(rst_n), .modeWrEn(modeWrEn), .modeField(modeField),
    .startEn(startEn), .startCol(startCol), .stopReq(stopReq),
    .beatAddr(beatAddr), .beatValid(beatValid), .beatLast(beatLast),
    .modeErr(modeErr), .startErr(startErr), .stopErr(stopErr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [COL_W-1:0] expBeat(logic [COL_W-1:0] col, bit len8, bit inter, int i);
    int s = int'(col[2:0]);
    int mask = len8 ? 7 : 3;
    int lowBits;
    if (inter)     lowBits = (s ^ i) & mask;
    else if (len8) lowBits = ((s ^ (i & 4)) & 4) | ((s + i) & 3);
    else           lowBits = (s + i) & 3;
    return (col & ~COL_W'(mask)) | COL_W'(lowBits);
  endfunction

  function automatic string orderTag(bit len8, bit inter);
    if (len8) return inter ? "R6" : "R5";
    return inter ? "R4" : "R3";
  endfunction

  task automatic checkBeat(logic [COL_W-1:0] col, bit len8, bit inter, int i, string tag);
    logic [COL_W-1:0] e = expBeat(col, len8, inter, i);
    int last = len8 ? 7 : 3;
    int fld = len8 ? 3 : 2;
    chk(beatValid === 1'b1, "R8", int'(beatValid), 1);
    chk(beatAddr === e, tag, int'(beatAddr), int'(e));
    chk((beatAddr >> fld) === (col >> fld), "R7", int'(beatAddr >> fld), int'(col >> fld));
    chk(beatLast === (i == last), "R8", int'(beatLast), int'(i == last));
  endtask

  task automatic setMode(bit len8, bit inter);
    modeWrEn = 1'b1;
    modeField = {inter, (len8 ? 3'b011 : 3'b010)};
    tick;
    modeWrEn = 1'b0;
    chk(modeErr === 1'b0, "R1", int'(modeErr), 0);
  endtask

  task automatic runBurst(logic [COL_W-1:0] col, bit len8, bit inter, string tag);
    int n = len8 ? 8 : 4;
    startEn = 1'b1;
    startCol = col;
    tick;
    startEn = 1'b0;
    for (int i = 0; i < n; i++) begin
      checkBeat(col, len8, inter, i, tag);
      tick;
    end
    chk(beatValid === 1'b0, "R8", int'(beatValid), 0);
  endtask

  task automatic testReset;
    chk(beatValid === 1'b0, "R8", int'(beatValid), 0);
    chk(beatLast === 1'b0, "R8", int'(beatLast), 0);
    chk({modeErr, startErr, stopErr} === 3'b000, "R2", int'({modeErr, startErr, stopErr}), 0);
    runBurst(10'h0A1, 1'b0, 1'b0, "R1");
  endtask

  task automatic testAllOrders;
    for (int m = 0; m < 4; m++) begin
      bit len8 = m[1];
      bit inter = m[0];
      setMode(len8, inter);
      for (int s = 0; s < 8; s++) begin
        logic [COL_W-1:0] col = {7'(s * 13 + 5), 3'(s)};
        runBurst(col, len8, inter, orderTag(len8, inter));
      end
    end
  endtask

  task automatic testBadMode;
    setMode(1'b1, 1'b1);
    modeWrEn = 1'b1;
    modeField = 4'b0111;
    tick;
    modeWrEn = 1'b0;
    chk(modeErr === 1'b1, "R2", int'(modeErr), 1);
    tick;
    chk(modeErr === 1'b0, "R2", int'(modeErr), 0);
    modeWrEn = 1'b1;
    modeField = 4'b0000;
    tick;
    modeWrEn = 1'b0;
    chk(modeErr === 1'b1, "R2", int'(modeErr), 1);
    runBurst(10'h15B, 1'b1, 1'b1, "R2");
  endtask

  task automatic testSeamless;
    logic [COL_W-1:0] a = 10'h203;
    logic [COL_W-1:0] b = 10'h0F6;
    setMode(1'b0, 1'b0);
    startEn = 1'b1;
    startCol = a;
    tick;
    startEn = 1'b0;
    for (int i = 0; i < 4; i++) begin
      checkBeat(a, 1'b0, 1'b0, i, "R9");
      if (i == 3) begin
        startEn = 1'b1;
        startCol = b;
      end
      tick;
    end
    startEn = 1'b0;
    chk(startErr === 1'b0, "R9", int'(startErr), 0);
    for (int i = 0; i < 4; i++) begin
      checkBeat(b, 1'b0, 1'b0, i, "R9");
      tick;
    end
    chk(beatValid === 1'b0, "R9", int'(beatValid), 0);
  endtask

  task automatic testLen4Cut;
    logic [COL_W-1:0] a = 10'h132;
    setMode(1'b0, 1'b1);
    startEn = 1'b1;
    startCol = a;
    tick;
    startEn = 1'b0;
    checkBeat(a, 1'b0, 1'b1, 0, "R4");
    tick;
    checkBeat(a, 1'b0, 1'b1, 1, "R4");
    startEn = 1'b1;
    startCol = 10'h3FF;
    tick;
    startEn = 1'b0;
    chk(startErr === 1'b1, "R10", int'(startErr), 1);
    checkBeat(a, 1'b0, 1'b1, 2, "R10");
    tick;
    chk(startErr === 1'b0, "R10", int'(startErr), 0);
    checkBeat(a, 1'b0, 1'b1, 3, "R10");
    tick;
    chk(beatValid === 1'b0, "R10", int'(beatValid), 0);
  endtask

  task automatic testLen8Cut;
    logic [COL_W-1:0] a = 10'h2C5;
    logic [COL_W-1:0] b = 10'h11A;
    setMode(1'b1, 1'b0);
    startEn = 1'b1;
    startCol = a;
    tick;
    startEn = 1'b0;
    checkBeat(a, 1'b1, 1'b0, 0, "R5");
    tick;
    checkBeat(a, 1'b1, 1'b0, 1, "R5");
    startEn = 1'b1;
    startCol = b;
    tick;
    startEn = 1'b0;
    chk(startErr === 1'b0, "R11", int'(startErr), 0);
    for (int i = 0; i < 8; i++) begin
      checkBeat(b, 1'b1, 1'b0, i, "R11");
      tick;
    end
    chk(beatValid === 1'b0, "R11", int'(beatValid), 0);
    startEn = 1'b1;
    startCol = a;
    tick;
    startEn = 1'b0;
    for (int i = 0; i < 2; i++) begin
      checkBeat(a, 1'b1, 1'b0, i, "R11");
      tick;
    end
    checkBeat(a, 1'b1, 1'b0, 2, "R11");
    startEn = 1'b1;
    startCol = b;
    tick;
    startEn = 1'b0;
    chk(startErr === 1'b1, "R11", int'(startErr), 1);
    for (int i = 3; i < 8; i++) begin
      checkBeat(a, 1'b1, 1'b0, i, "R11");
      tick;
    end
    chk(beatValid === 1'b0, "R11", int'(beatValid), 0);
  endtask

  task automatic testStop;
    logic [COL_W-1:0] a = 10'h0E1;
    setMode(1'b0, 1'b0);
    stopReq = 1'b1;
    tick;
    stopReq = 1'b0;
    chk(stopErr === 1'b1, "R12", int'(stopErr), 1);
    chk(beatValid === 1'b0, "R12", int'(beatValid), 0);
    startEn = 1'b1;
    startCol = a;
    tick;
    startEn = 1'b0;
    checkBeat(a, 1'b0, 1'b0, 0, "R12");
    stopReq = 1'b1;
    tick;
    stopReq = 1'b0;
    chk(stopErr === 1'b1, "R12", int'(stopErr), 1);
    for (int i = 1; i < 4; i++) begin
      checkBeat(a, 1'b0, 1'b0, i, "R12");
      tick;
    end
    chk(beatValid === 1'b0, "R12", int'(beatValid), 0);
    chk(stopErr === 1'b0, "R12", int'(stopErr), 0);
  endtask

  task automatic testModeMidBurst;
    logic [COL_W-1:0] a = 10'h376;
    setMode(1'b0, 1'b0);
    startEn = 1'b1;
    startCol = a;
    tick;
    startEn = 1'b0;
    checkBeat(a, 1'b0, 1'b0, 0, "R13");
    modeWrEn = 1'b1;
    modeField = 4'b1011;
    tick;
    modeWrEn = 1'b0;
    for (int i = 1; i < 4; i++) begin
      checkBeat(a, 1'b0, 1'b0, i, "R13");
      tick;
    end
    chk(beatValid === 1'b0, "R13", int'(beatValid), 0);
    runBurst(a, 1'b1, 1'b1, "R13");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset;
    testAllOrders;
    testBadMode;
    testSeamless;
    testLen4Cut;
    testLen8Cut;
    testStop;
    testModeMidBurst;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule